// File: doc/BRIEF.md
# Cut-Through Mesh Router Crossbar

This block is the switch fabric of a 2-D mesh or torus router with four network ports (east, west, north, south) and one local port. Every network input owns a dedicated wire to the output on the far side of the router, so straight traffic never competes for wiring. A flit that changes dimension is steered through crosspoints onto another port's line. Some pairs of such turns therefore overlap on a wire segment and cannot cross the fabric in the same cycle. Injection reaches the network outputs, and network inputs reach ejection, through a separate multiplexer path beside the 4x4 fabric.

Each cycle, every input presents a valid bit, a flit and a destination code. The block returns a grant in the same cycle. Every output runs its own round-robin arbiter. A second stage removes wire clashes between turns by using a one-bit dimension preference that swaps after each clash. A refused input keeps its request and retries in a later cycle. Granted flits are registered, so each one appears on its output exactly one clock after the grant.

Top module: `mesh_cutxbar`

## Requirements
- R1: During synchronous reset no grant is issued, even if requests are present. After reset every output valid is low, every output arbiter ranks port 0 first, and the dimension preference favours horizontal turns.
- R2: Port index 0 is east, 1 west, 2 north, 3 south, 4 local (injection on the input side, ejection on the output side). Destination codes use the same numbers. A straight request (east to west, west to east, north to south, south to north) is never refused because of wiring; only output contention can refuse it.
- R3: A grant is given only to a valid request and in the cycle the request is presented. The granted flit appears on the addressed output, with its valid set, exactly one clock edge later. An output with no grant has its valid low in the next cycle.
- R4: Each output takes at most one flit per cycle. Contending inputs are served round-robin: after an output grants input k, input k+1 (mod 5) ranks first for that output. A candidate that is then refused by the wire check does not move that output's pointer.
- R5: A horizontal-to-vertical turn and a vertical-to-horizontal turn clash when they share a segment. The clashing pairs are east-to-north with north-to-west, east-to-south with north-to-east, west-to-north with south-to-west, and west-to-south with south-to-east. No other single pair clashes.
- R6: When both inputs of one dimension are turning, any turn from the other dimension clashes with them.
- R7: On a clash, all turns of the preferred dimension are granted and all turns of the other dimension are refused. The preference then switches to the refused dimension, so an identical retry in the next cycle is granted.
- R8: When no vertical-to-horizontal turn is among the candidates (dimension-ordered routing, X first), the wire check refuses nothing.
- R9: Injection may address any network output, and any network input may address ejection. These transfers use the parallel path and never take part in wire clashes.
- R10: The following requests are never granted and produce no output: a network input addressing its own port (U-turn), injection addressing ejection, and destination codes 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 5 | Request valid per input port |
| in_dest | input | 5x3 | Destination code per input port |
| in_flit | input | 5xFLIT_W | Flit per input port |
| in_grant | output | 5 | Same-cycle grant per input port |
| out_valid | output | 5 | Registered valid per output port |
| out_flit | output | 5xFLIT_W | Registered flit per output port |

## Verification
The assertions check four rules on every cycle, using only the port signals: no output is granted twice, no clashing pair of turns or dimension overflow is ever granted together, straight and dimension-ordered traffic are never refused by the wire check, and outputs follow grants by exactly one cycle. Inside the turn filter, an assertion checks that an identical retry after a clash is always granted. Other behaviours can only be shown by the bench's scenarios with hand-computed results: the exact round-robin order at a contended output, which member of a clash wins for a given preference history, and that a refused candidate does not move its output's pointer.

// File: rtl/mesh_cutxbar_pkg.sv
// Shared constants, port numbering and turn classification for the
// cut-through crossbar. Assumes four network ports plus one local port.
package mesh_cutxbar_pkg;

    localparam int NET_PORTS = 4;
    localparam int ALL_PORTS = NET_PORTS + 1;
    localparam int LOCAL_IDX = NET_PORTS;
    localparam int DEST_W    = 3;

    localparam logic [DEST_W-1:0] DST_LOCAL = 3'd4;

    // Shared-segment table: bit {h, v} is set when horizontal-to-vertical
    // turn h = {src is west, dst is south} and vertical-to-horizontal turn
    // v = {src is south, dst is east} overlap on a wire segment.
    localparam logic [15:0] SHARED_SEG = 16'h8421;

    typedef enum logic [1:0] {
        TURN_NONE,
        TURN_HV,
        TURN_VH
    } turn_e;

    // Classify a network-port request as straight/none, H-to-V or V-to-H.
    function automatic turn_e turn_kind(input logic [2:0] src,
                                        input logic [DEST_W-1:0] dst);
        if (dst[2])
            return TURN_NONE;
        if (src[1] == dst[1])
            return TURN_NONE;
        return src[1] ? TURN_VH : TURN_HV;
    endfunction

    // A request is legal unless it is a U-turn, injection-to-ejection,
    // or uses an unassigned code.
    function automatic logic legal_req(input logic [2:0] src,
                                       input logic [DEST_W-1:0] dst);
        if (dst > DST_LOCAL)
            return 1'b0;
        return dst != src;
    endfunction

endpackage

// File: rtl/mesh_cutxbar_rrarb.sv
// Round-robin arbiter for one output. Picks one requester starting from
// the pointer. The pointer moves past the winner only when the caller
// reports that the grant was actually taken.
module mesh_cutxbar_rrarb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         taken,
    output logic [N-1:0] gnt
);

    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] win_idx;

    // Scan requesters from the pointer and pick the first one found.
    always_comb begin
        int  idx;
        logic found;
        gnt     = '0;
        win_idx = '0;
        found   = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                win_idx  = PTR_W'(idx);
                found    = 1'b1;
            end
        end
    end

    // Move the pointer to the port after an accepted winner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (taken)
            ptr <= (int'(win_idx) == N - 1) ? '0 : win_idx + 1'b1;
    end

endmodule

// File: rtl/mesh_cutxbar_turnfilt.sv
// Wire-clash filter for the network inputs. Assumes the candidates
// already won their outputs. It refuses one dimension's turns when turns
// overlap on a shared segment or one dimension uses all its turn wiring.
module mesh_cutxbar_turnfilt
    import mesh_cutxbar_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NET_PORTS-1:0]             cand,
    input  logic [NET_PORTS-1:0][DEST_W-1:0] dest,
    output logic [NET_PORTS-1:0]             keep
);

    logic                 fav_h;
    logic [NET_PORTS-1:0] hv;
    logic [NET_PORTS-1:0] vh;
    logic [1:0]           h_idx;
    logic [1:0]           v_idx;
    logic                 any_h;
    logic                 any_v;
    logic                 clash;

    // Mark which candidates turn, and in which direction.
    always_comb begin
        for (int i = 0; i < NET_PORTS; i++) begin
            hv[i] = cand[i] && (turn_kind(3'(i), dest[i]) == TURN_HV);
            vh[i] = cand[i] && (turn_kind(3'(i), dest[i]) == TURN_VH);
        end
    end

    // Detect a clash and drop the turns of the non-preferred dimension.
    always_comb begin
        h_idx = hv[0] ? {1'b0, dest[0][0]} : {1'b1, dest[1][0]};
        v_idx = vh[2] ? {1'b0, ~dest[2][0]} : {1'b1, ~dest[3][0]};
        any_h = |hv;
        any_v = |vh;
        clash = (hv[0] && hv[1] && any_v) ||
                (vh[2] && vh[3] && any_h) ||
                (any_h && any_v && SHARED_SEG[{h_idx, v_idx}]);
        if (!clash)
            keep = cand;
        else if (fav_h)
            keep = cand & ~vh;
        else
            keep = cand & ~hv;
    end

    // Hand the preference to the dimension that lost a clash.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fav_h <= 1'b1;
        else if (clash)
            fav_h <= ~fav_h;
    end

    // An identical retry after a refusal must go through.
    assert_retry_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (cand == $past(cand)) && (dest == $past(dest)) &&
         (($past(cand) & ~$past(keep)) != '0))
        |-> ((keep & $past(cand & ~keep)) == $past(cand & ~keep)));

endmodule

// File: rtl/mesh_cutxbar_outreg.sv
// Output register for one crossbar output. Assumes the select vector is
// one-hot or zero. It loads the selected flit and raises valid one cycle
// after the grant.
module mesh_cutxbar_outreg
    import mesh_cutxbar_pkg::*;
#(
    parameter int FLIT_W = 128
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ALL_PORTS-1:0]             sel,
    input  logic [ALL_PORTS-1:0][FLIT_W-1:0] flits,
    output logic                             valid_q,
    output logic [FLIT_W-1:0]                flit_q
);

    logic [FLIT_W-1:0] nxt;

    // AND-OR multiplexer over the one-hot select.
    always_comb begin
        nxt = '0;
        for (int i = 0; i < ALL_PORTS; i++)
            if (sel[i])
                nxt = nxt | flits[i];
    end

    // Register the traversing flit; hold the data when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            flit_q  <= '0;
        end else begin
            valid_q <= |sel;
            if (|sel)
                flit_q <= nxt;
        end
    end

endmodule

// File: rtl/mesh_cutxbar.sv
// Cut-through crossbar top. Output arbitration runs first, then the
// wire-clash filter, then one output register per port. Assumes the
// upstream holds a refused request until it is granted.
module mesh_cutxbar
    import mesh_cutxbar_pkg::*;
#(
    parameter int FLIT_W = 128
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ALL_PORTS-1:0]             in_valid,
    input  logic [ALL_PORTS-1:0][DEST_W-1:0] in_dest,
    input  logic [ALL_PORTS-1:0][FLIT_W-1:0] in_flit,
    output logic [ALL_PORTS-1:0]             in_grant,
    output logic [ALL_PORTS-1:0]             out_valid,
    output logic [ALL_PORTS-1:0][FLIT_W-1:0] out_flit
);

    logic [ALL_PORTS-1:0][ALL_PORTS-1:0] req_m;
    logic [ALL_PORTS-1:0][ALL_PORTS-1:0] arb_g;
    logic [ALL_PORTS-1:0][ALL_PORTS-1:0] fin_g;
    logic [ALL_PORTS-1:0]                cand_all;
    logic [NET_PORTS-1:0]                keep;

    // Build the output-by-input request matrix from legal requests.
    always_comb begin
        for (int o = 0; o < ALL_PORTS; o++)
            for (int i = 0; i < ALL_PORTS; i++)
                req_m[o][i] = in_valid[i] && (in_dest[i] == DEST_W'(o)) &&
                              legal_req(3'(i), in_dest[i]);
    end

    // Collect, per input, whether it won its output's arbiter.
    always_comb begin
        cand_all = '0;
        for (int o = 0; o < ALL_PORTS; o++)
            for (int i = 0; i < ALL_PORTS; i++)
                if (arb_g[o][i])
                    cand_all[i] = 1'b1;
    end

    // Combine the filtered network grants with the local path; none in reset.
    always_comb begin
        in_grant = rst_n ? {cand_all[LOCAL_IDX], keep} : '0;
        for (int o = 0; o < ALL_PORTS; o++)
            fin_g[o] = arb_g[o] & in_grant;
    end

    mesh_cutxbar_turnfilt u_turnfilt (
        .clk   (clk),
        .rst_n (rst_n),
        .cand  (cand_all[NET_PORTS-1:0]),
        .dest  (in_dest[NET_PORTS-1:0]),
        .keep  (keep)
    );

    generate
        for (genvar o = 0; o < ALL_PORTS; o++) begin : g_out
            mesh_cutxbar_rrarb #(
                .N (ALL_PORTS)
            ) u_arb (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (req_m[o]),
                .taken (|fin_g[o]),
                .gnt   (arb_g[o])
            );

            mesh_cutxbar_outreg #(
                .FLIT_W (FLIT_W)
            ) u_oreg (
                .clk     (clk),
                .rst_n   (rst_n),
                .sel     (fin_g[o]),
                .flits   (in_flit),
                .valid_q (out_valid[o]),
                .flit_q  (out_flit[o])
            );
        end
    endgenerate

    // ---------------- checks built from the port signals ----------------
    logic [ALL_PORTS-1:0][ALL_PORTS-1:0] port_view;
    logic [1:0]                          g_hv;
    logic [1:0]                          g_vh;
    logic                                pair_hit;
    logic                                cand_vh;

    // Re-derive granted traffic and granted turns from the ports.
    always_comb begin
        for (int o = 0; o < ALL_PORTS; o++)
            for (int i = 0; i < ALL_PORTS; i++)
                port_view[o][i] = in_grant[i] && (in_dest[i] == DEST_W'(o));
        for (int a = 0; a < 2; a++) begin
            g_hv[a] = in_grant[a] && (turn_kind(3'(a), in_dest[a]) == TURN_HV);
            g_vh[a] = in_grant[a+2] && (turn_kind(3'(a+2), in_dest[a+2]) == TURN_VH);
        end
        pair_hit = 1'b0;
        for (int a = 0; a < 2; a++)
            for (int b = 0; b < 2; b++)
                if (g_hv[a] && g_vh[b] &&
                    SHARED_SEG[{1'(a), in_dest[a][0], 1'(b), ~in_dest[b+2][0]}])
                    pair_hit = 1'b1;
        cand_vh = (cand_all[2] && (turn_kind(3'd2, in_dest[2]) == TURN_VH)) ||
                  (cand_all[3] && (turn_kind(3'd3, in_dest[3]) == TURN_VH));
    end

    assert_no_shared_seg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_hit);

    assert_dim_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !((&g_hv && |g_vh) || (&g_vh && |g_hv)));

    assert_dor_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_vh |-> (in_grant[NET_PORTS-1:0] == cand_all[NET_PORTS-1:0]));

    generate
        for (genvar o = 0; o < ALL_PORTS; o++) begin : g_chk_out
            assert_one_flit_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(port_view[o]));
            assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (out_valid[o] == $past(|port_view[o])));
        end
        for (genvar i = 0; i < ALL_PORTS; i++) begin : g_chk_in
            assert_grant_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
                in_grant[i] |-> in_valid[i]);
            assert_no_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
                in_grant[i] |-> ((in_dest[i] <= DST_LOCAL) && (in_dest[i] != DEST_W'(i))));
        end
        for (genvar i = 0; i < NET_PORTS; i++) begin : g_chk_straight
            assert_straight_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (cand_all[i] && (in_dest[i] == DEST_W'(i ^ 1))) |-> in_grant[i]);
        end
    endgenerate

endmodule

// File: tb/mesh_cutxbar_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: run() pushes the expected output set of each cycle;
// the monitor pops one set per cycle and compares it with the outputs.
module mesh_cutxbar_tb_top;

    localparam int FW = 128;
    localparam int E = 0, W = 1, N = 2, S = 3, L = 4;

    typedef struct {
        logic [4:0]         v;
        logic [4:0][FW-1:0] f;
        string              tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [4:0]         v;
    logic [4:0][2:0]    d;
    logic [4:0][FW-1:0] f;
    logic [4:0]         grant;
    logic [4:0]         ovalid;
    logic [4:0][FW-1:0] oflit;

    exp_t sb_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    always #4 clk = ~clk;

    mesh_cutxbar #(.FLIT_W(FW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (v),
        .in_dest   (d),
        .in_flit   (f),
        .in_grant  (grant),
        .out_valid (ovalid),
        .out_flit  (oflit)
    );

    task automatic check(input string what, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] mk(input int i, input int n);
        return {(FW/16){8'(n), 4'(i), 4'hA}};
    endfunction

    task automatic clr();
        v = '0;
        d = '0;
        f = '0;
    endtask

    task automatic setreq(input int i, input int dst, input int n);
        v[i] = 1'b1;
        d[i] = 3'(dst);
        f[i] = mk(i, n);
    endtask

    // Check grants for the current inputs, queue expected outputs, advance.
    task automatic run(input logic [4:0] exp_g, input string tag);
        exp_t e;
        #1;
        check($sformatf("%s grant", tag), FW'(grant), FW'(exp_g));
        e.v   = '0;
        e.f   = '0;
        e.tag = tag;
        for (int i = 0; i < 5; i++)
            if (exp_g[i]) begin
                e.v[d[i]] = 1'b1;
                e.f[d[i]] = f[i];
            end
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: compare registered outputs one cycle after each grant (R3).
    always @(negedge clk) begin
        exp_t e;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            for (int p = 0; p < 5; p++) begin
                check($sformatf("R3 %s out_valid[%0d]", e.tag, p), FW'(ovalid[p]), FW'(e.v[p]));
                if (e.v[p])
                    check($sformatf("R3 %s out_flit[%0d]", e.tag, p), oflit[p], e.f[p]);
            end
        end
    end

    initial begin
        #(8 * 20000);
        total++;
        bad++;
        $display("FAIL watchdog R3 act=running exp=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        clr();
        setreq(E, W, 1);
        repeat (2) @(negedge clk);
        #1;
        check("R1 grant in reset", FW'(grant), '0);
        check("R1 out_valid in reset", FW'(ovalid), '0);
        @(negedge clk);
        rst_n = 1'b1;
        clr();

        // R2: all four straight paths together
        setreq(E, W, 2); setreq(W, E, 2); setreq(N, S, 2); setreq(S, N, 2);
        run(5'b01111, "R2 straight");

        // R5: east-to-north vs north-to-west, horizontal preferred
        clr(); setreq(E, N, 3); setreq(N, W, 3);
        run(5'b00001, "R5 EN-NW clash");
        // R7: identical retry now goes to the vertical turn
        run(5'b00100, "R7 retry");

        // R5: east-to-north with north-to-east share nothing
        clr(); setreq(E, N, 4); setreq(N, E, 4);
        run(5'b00101, "R5 EN-NE free");

        // R6: both horizontal inputs turning block a vertical turn
        clr(); setreq(E, N, 5); setreq(W, S, 5); setreq(N, E, 5);
        run(5'b00011, "R6 dim full");

        // R4: three contenders at north output, round-robin order
        clr(); setreq(E, N, 6); setreq(W, N, 6); setreq(S, N, 6);
        run(5'b00010, "R4 rr1");
        run(5'b01000, "R4 rr2");
        run(5'b00001, "R4 rr3");
        run(5'b00010, "R4 rr4");

        // R9: injection to east, west input to ejection
        clr(); setreq(L, E, 7); setreq(W, L, 7);
        run(5'b10010, "R9 local path");

        // R4/R9: injection and east compete for west (pointer held by refusal)
        clr(); setreq(L, W, 8); setreq(E, W, 8);
        run(5'b10000, "R4 inj first");
        run(5'b00001, "R4 east next");

        // R10: U-turns, injection-to-ejection and unused codes
        clr(); setreq(L, L, 9); setreq(E, E, 9); setreq(N, 7, 9); setreq(S, S, 9);
        run(5'b00000, "R10 ignored");

        // R8: dimension-ordered traffic plus local transfers
        clr(); setreq(E, N, 10); setreq(W, S, 10); setreq(L, E, 10); setreq(S, L, 10);
        run(5'b11011, "R8 dor");

        // R5/R7: west-to-north vs south-to-west with vertical preferred
        clr(); setreq(S, W, 11); setreq(W, N, 11);
        run(5'b01000, "R7 WN-SW vertical wins");
        run(5'b00010, "R7 WN-SW retry");

        clr();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule